// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block is the digital control and status logic that sits beside one analog voltage comparator. The comparator's result arrives as a raw bit with no timing relation to the system clock. The block brings it into the clock domain through a flop chain and shows the clean level as a status bit. It watches that level for transitions and records rising and falling transitions in two separate sticky flags. Each flag drives its own interrupt request, gated by an enable that the system's interrupt-enable logic supplies.

Software sees one 8-bit control/status register. The layout is: bit 7 turns the comparator on, bit 6 is the synchronized comparator level (read-only), bit 5 is the rising-transition flag, bit 4 is the falling-transition flag, bits 3:2 set positive hysteresis and bits 1:0 set negative hysteresis. The enable bit and both hysteresis fields also leave the block on pins that go to the analog core. Software clears a flag by writing 0 to its bit. Writing 1 to a flag bit leaves the flag as it is.

Top module: `cmp_edge_ctrl`

## Requirements
- R1: After reset, the register reads 0x00, both interrupt requests are low, the enable pin is low and both hysteresis pins are 0.
- R2: A write loads bit 7 into the enable, which reads back at bit 7 and drives `cmpEnable` from the clock edge that takes the write.
- R3: A write loads bits 3:2 into the positive hysteresis field and bits 1:0 into the negative one. Both read back in place and drive `hystPos` and `hystNeg`.
- R4: Bit 6 shows the raw comparator input as sampled two rising clock edges earlier, through a two-stage synchronizer that is reset to 0.
- R5: When bit 6 goes from 0 to 1 while the comparator is enabled, bit 5 (rising flag) is set at the next clock edge.
- R6: When bit 6 goes from 1 to 0 while the comparator is enabled, bit 4 (falling flag) is set at the next clock edge.
- R7: A flag stays set until a write puts 0 in its bit. A write of 1 to a flag bit does not change the flag.
- R8: While the comparator is disabled, no flag is set and existing flags keep their value. A level change that happened while disabled raises no flag when the comparator is enabled again.
- R9: If a write clears a flag in the same cycle that a new transition of that type sets it, the flag ends up set.
- R10: `irqRise` is high exactly when the rising flag and `riseIrqEn` are both high. `irqFall` is high exactly when the falling flag and `fallIrqEn` are both high.
- R11: The value written to bit 6 is ignored. Bit 6 always shows the synchronized comparator level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmpRaw | input | 1 | Raw comparator result, asynchronous |
| wrEn | input | 1 | Register write strobe, one cycle |
| wrData | input | 8 | Register write value |
| rdData | output | 8 | Register read value |
| riseIrqEn | input | 1 | Enable for the rising-edge interrupt |
| fallIrqEn | input | 1 | Enable for the falling-edge interrupt |
| irqRise | output | 1 | Rising-edge interrupt request |
| irqFall | output | 1 | Falling-edge interrupt request |
| cmpEnable | output | 1 | Comparator power-on to the analog core |
| hystPos | output | 2 | Positive hysteresis setting to the analog core |
| hystNeg | output | 2 | Negative hysteresis setting to the analog core |

## Verification
Different results appear at different delays. A raw input level shows up in the status bit two clock edges after it is sampled. The matching flag is set one edge after that, so three edges after the sample. Register writes and flag clears take effect at the edge that takes the write. The interrupt outputs follow the flags and the enable inputs with no register in between. The bench keeps a behavioural model that moves one step at each rising edge and has the same delays. It compares every output field 2 ns after that edge, before the inputs change at the falling edge. Directed sequences place a clear on the exact edge where a new transition lands, and toggle the input while the comparator is disabled.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

  localparam int REG_W    = 8;
  localparam int HYST_W   = 2;

  // Bit positions in the control/status register; software depends on them.
  localparam int EN_BIT   = 7;
  localparam int STAT_BIT = 6;
  localparam int RISE_BIT = 5;
  localparam int FALL_BIT = 4;
  localparam int HP_LSB   = 2;
  localparam int HN_LSB   = 0;

  typedef struct packed {
    logic              enable;
    logic [HYST_W-1:0] hystPos;
    logic [HYST_W-1:0] hystNeg;
  } cmpCfg_t;

  // Strobes from the control decoder to the datapath.
  typedef struct packed {
    logic    setRise;
    logic    setFall;
    logic    clrRise;
    logic    clrFall;
    logic    cfgLoad;
    cmpCfg_t cfgNext;
  } cmpStrobe_t;

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];

  // R4: every stage takes the stage before it one cycle later
  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stageChk
      p_stage_shift_r4: assert property (@(posedge clk) disable iff (!rstN)
        chain[i] == $past(chain[i-1]));
    end
  endgenerate

endmodule

// File: rtl/cmp_ctrl.sv
module cmp_ctrl
  import cmp_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncBit,
  input  logic             curEnable,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output cmpStrobe_t       strb
);

  logic prevBit;
  logic riseSeen;
  logic fallSeen;
  logic unusedStatusWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevBit <= 1'b0;
    else       prevBit <= syncBit;
  end

  assign riseSeen = syncBit & ~prevBit;
  assign fallSeen = ~syncBit & prevBit;

  // Bit 6 is read-only; its write value is dropped here.
  assign unusedStatusWr = wrData[STAT_BIT];

  always_comb begin
    strb                 = '0;
    strb.setRise         = curEnable & riseSeen;
    strb.setFall         = curEnable & fallSeen;
    strb.clrRise         = wrEn & ~wrData[RISE_BIT];
    strb.clrFall         = wrEn & ~wrData[FALL_BIT];
    strb.cfgLoad         = wrEn;
    strb.cfgNext.enable  = wrData[EN_BIT];
    strb.cfgNext.hystPos = wrData[HP_LSB +: HYST_W];
    strb.cfgNext.hystNeg = wrData[HN_LSB +: HYST_W];
  end

  // R5: a rising set strobe only follows a 0 -> 1 step of the synchronized bit
  p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.setRise |-> (syncBit && !$past(syncBit)));

  // R6: a falling set strobe only follows a 1 -> 0 step of the synchronized bit
  p_fall_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.setFall |-> (!syncBit && $past(syncBit)));

endmodule

// File: rtl/cmp_dp.sv
module cmp_dp
  import cmp_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cmpStrobe_t       strb,
  input  logic             syncBit,
  input  logic             riseIrqEn,
  input  logic             fallIrqEn,
  output cmpCfg_t          cfg,
  output logic [REG_W-1:0] rdData,
  output logic             irqRise,
  output logic             irqFall
);

  logic riseFlag;
  logic fallFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cfg <= '0;
    else if (strb.cfgLoad) cfg <= strb.cfgNext;
  end

  // A set strobe takes priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             riseFlag <= 1'b0;
    else if (strb.setRise) riseFlag <= 1'b1;
    else if (strb.clrRise) riseFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             fallFlag <= 1'b0;
    else if (strb.setFall) fallFlag <= 1'b1;
    else if (strb.clrFall) fallFlag <= 1'b0;
  end

  always_comb begin
    rdData                     = '0;
    rdData[EN_BIT]             = cfg.enable;
    rdData[STAT_BIT]           = syncBit;
    rdData[RISE_BIT]           = riseFlag;
    rdData[FALL_BIT]           = fallFlag;
    rdData[HP_LSB +: HYST_W]   = cfg.hystPos;
    rdData[HN_LSB +: HYST_W]   = cfg.hystNeg;
  end

  assign irqRise = riseFlag & riseIrqEn;
  assign irqFall = fallFlag & fallIrqEn;

  // R7: a flag only drops after a clear strobe
  p_rise_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(riseFlag) |-> $past(strb.clrRise));
  p_fall_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fallFlag) |-> $past(strb.clrFall));

  // R9: a set strobe leaves the flag set even with a clear alongside
  p_rise_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.setRise |=> riseFlag);
  p_fall_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.setFall |=> fallFlag);

  // R8: a flag only rises while the comparator was enabled
  p_rise_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(riseFlag) |-> $past(cfg.enable));
  p_fall_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fallFlag) |-> $past(cfg.enable));

endmodule

// File: rtl/cmp_edge_ctrl.sv
module cmp_edge_ctrl
  import cmp_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpRaw,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic              riseIrqEn,
  input  logic              fallIrqEn,
  output logic              irqRise,
  output logic              irqFall,
  output logic              cmpEnable,
  output logic [HYST_W-1:0] hystPos,
  output logic [HYST_W-1:0] hystNeg
);

  logic       syncBit;
  cmpStrobe_t strb;
  cmpCfg_t    cfg;

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (cmpRaw),
    .syncOut (syncBit)
  );

  cmp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .syncBit   (syncBit),
    .curEnable (cfg.enable),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .strb      (strb)
  );

  cmp_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .syncBit   (syncBit),
    .riseIrqEn (riseIrqEn),
    .fallIrqEn (fallIrqEn),
    .cfg       (cfg),
    .rdData    (rdData),
    .irqRise   (irqRise),
    .irqFall   (irqFall)
  );

  assign cmpEnable = cfg.enable;
  assign hystPos   = cfg.hystPos;
  assign hystNeg   = cfg.hystNeg;

  // R10: a request is only raised when the readable flag and its enable are both high
  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqRise |-> (rdData[RISE_BIT] && riseIrqEn));
  p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqFall |-> (rdData[FALL_BIT] && fallIrqEn));

endmodule

// File: tb/cmp_edge_ctrl_bench.sv
`timescale 1ns/1ps
module cmp_edge_ctrl_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmpRaw = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       riseIrqEn = 1'b0;
  logic       fallIrqEn = 1'b0;
  logic [7:0] rdData;
  logic       irqRise, irqFall, cmpEnable;
  logic [1:0] hystPos, hystNeg;

  int total = 0;
  int bad = 0;
  bit checking = 1'b0;
  bit finished = 1'b0;

  // Behavioural model state
  logic mEn, mStatus, mStatusPrev, mRise, mFall;
  logic [1:0] mHp, mHn;
  logic hist[$];

  always #4 clk = ~clk;

  cmp_edge_ctrl u_cmp_edge_ctrl (
    .clk(clk), .rstN(rstN), .cmpRaw(cmpRaw), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .riseIrqEn(riseIrqEn), .fallIrqEn(fallIrqEn),
    .irqRise(irqRise), .irqFall(irqFall), .cmpEnable(cmpEnable),
    .hystPos(hystPos), .hystNeg(hystNeg)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Model steps at each rising edge, then compares 2 ns later.
  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mStatus = 0; mStatusPrev = 0; mRise = 0; mFall = 0;
      mHp = 0; mHn = 0; hist.delete();
    end else begin
      logic nRise, nFall;
      nRise = mRise; nFall = mFall;
      if (wrEn && !wrData[5]) nRise = 0;
      if (wrEn && !wrData[4]) nFall = 0;
      if (mEn && mStatus && !mStatusPrev) nRise = 1;
      if (mEn && !mStatus && mStatusPrev) nFall = 1;
      if (wrEn) begin
        mEn = wrData[7]; mHp = wrData[3:2]; mHn = wrData[1:0];
      end
      mRise = nRise; mFall = nFall;
      mStatusPrev = mStatus;
      hist.push_front(cmpRaw);
      if (hist.size() > 2) void'(hist.pop_back());
      mStatus = (hist.size() == 2) ? hist[1] : 1'b0;
    end
    #2;
    if (checking && !finished) begin
      chk("R2 enable bit", {7'd0, rdData[7]}, {7'd0, mEn});
      chk("R2 enable pin", {7'd0, cmpEnable}, {7'd0, mEn});
      chk("R4/R11 status bit", {7'd0, rdData[6]}, {7'd0, mStatus});
      chk("R5/R7/R8/R9 rise flag", {7'd0, rdData[5]}, {7'd0, mRise});
      chk("R6/R7/R8/R9 fall flag", {7'd0, rdData[4]}, {7'd0, mFall});
      chk("R3 hyst readback", {4'd0, rdData[3:0]}, {4'd0, mHp, mHn});
      chk("R3 hyst pins", {4'd0, hystPos, hystNeg}, {4'd0, mHp, mHn});
      chk("R10 rise irq", {7'd0, irqRise}, {7'd0, mRise & riseIrqEn});
      chk("R10 fall irq", {7'd0, irqFall}, {7'd0, mFall & fallIrqEn});
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = $urandom;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    idle(1);
    // R1: reset values
    chk("R1 reset reg", rdData, 8'h00);
    chk("R1 reset pins", {3'd0, irqRise, irqFall, cmpEnable, hystPos == 0, hystNeg == 0}, 8'h03);
    checking = 1'b1;

    riseIrqEn = 1; fallIrqEn = 1;
    wr(8'h89);                         // enable, hystPos=2, hystNeg=1
    chk("R3 hyst directed", {4'd0, hystPos, hystNeg}, 8'h09);
    cmpRaw = 1; idle(4);
    chk("R5 rise directed", {6'd0, rdData[5:4]}, 8'h02);
    cmpRaw = 0; idle(4);
    chk("R6 fall directed", {6'd0, rdData[5:4]}, 8'h03);
    wr(8'h99);                         // clear rise only, keep fall
    chk("R7 clear directed", {6'd0, rdData[5:4]}, 8'h01);
    wr(8'hD9);                         // bit 6 written as 1
    chk("R11 status directed", {7'd0, rdData[6]}, 8'h00);

    // R9: clear lands on the same edge as a new rising transition
    wr(8'hB9);
    @(negedge clk); cmpRaw = 1;
    @(negedge clk);
    @(negedge clk); wrEn = 1; wrData = 8'h89;
    @(negedge clk); wrEn = 0;
    chk("R9 set wins", {6'd0, rdData[5:4]}, 8'h02);

    // R8: disabled, toggle input, then re-enable at the new level
    wr(8'h00);
    cmpRaw = 0; idle(5);
    cmpRaw = 1; idle(5);
    chk("R8 no flag while off", {6'd0, rdData[5:4]}, 8'h00);
    wr(8'h80); idle(4);
    chk("R8 no flag on re-enable", {6'd0, rdData[5:4]}, 8'h00);
    cmpRaw = 0; idle(5);
    wr(8'h30);                         // disable, keep flags
    cmpRaw = 1; idle(5);
    chk("R8 flags kept while off", {6'd0, rdData[5:4]}, 8'h01);

    // Mixed traffic
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) cmpRaw = ~cmpRaw;
      riseIrqEn = ($urandom_range(0, 7) != 0);
      fallIrqEn = ($urandom_range(0, 7) != 0);
      wrEn = ($urandom_range(0, 9) == 0);
      wrData = $urandom;
      if ($urandom_range(0, 1) == 0) wrData[7] = 1'b1;
    end
    @(negedge clk); wrEn = 0;
    idle(4);
    finish_run();
  end

endmodule